// File: doc/BRIEF.md
# Two-Channel Sampling Converter Control Interface

This block holds the digital side of a two-channel, 12-bit sampling converter. A falling edge on the sample strobe starts a conversion, but only when the chip is selected, powered up and idle. A down-counter then runs for a fixed number of clocks. While it runs, the end-of-conversion flag stays low. The channel-select input is captured when the conversion starts and is kept as a channel tag.

When the counter expires, a result latch loads the word from the quantizer stub, together with its channel tag. An active-low interrupt flag is raised at the same time. A host reads the result by asserting the output-enable, select and read inputs while no conversion is running. The result then appears on a gated data bus, modelled as a data word plus a drive-enable. A read with the chip selected clears the interrupt. A power-down input aborts conversions and holds the converter in standby.

All inputs are sampled on the rising clock edge. All outputs are registers.

Top module: `adc_ctl_if`

## Requirements
- R1: While reset is high, and in the cycle after it, eoc_n = 1, irq_n = 1, bus_oe = 0, bus_data = 0 and bus_chan = 0.
- R2: A conversion starts at a clock edge where sh_n is 0, sh_n was 1 at the previous edge, cs_n = 0, pd_n = 1 and no conversion is running. eoc_n reads 0 in the cycle after that edge. A falling sh_n with cs_n = 1 starts nothing.
- R3: eoc_n stays low for exactly CONV_CYCLES clock cycles (default 12) and then returns high.
- R4: A falling sh_n while a conversion is running is ignored. It neither restarts nor extends the conversion.
- R5: ch_sel is captured at the start edge, with 0 meaning channel one and 1 meaning channel two. This value becomes the result's bus_chan tag. Later changes to ch_sel have no effect on that conversion.
- R6: The result latch loads the conv_result value present at the edge where eoc_n returns high. It holds that word and its tag until the next conversion completes.
- R7: irq_n falls in the same cycle that eoc_n returns high, provided rd_n is 1. It stays low until an edge where rd_n = 0 and cs_n = 0, after which it reads 1.
- R8: irq_n reads 1 in every cycle after an edge with rd_n = 0, whatever cs_n is. A read with cs_n = 1 does not clear the pending interrupt, so irq_n falls again once rd_n returns high.
- R9: bus_oe is 1 only in the cycle after an edge where oe = 1, cs_n = 0 and rd_n = 0, and only when no conversion is running or starting at that edge. While bus_oe is 1, bus_data and bus_chan show the latch. Otherwise both read 0.
- R10: An edge with pd_n = 0 aborts any running conversion, with no latch load. After that edge, eoc_n = 1 and irq_n = 1. Strobes are ignored until pd_n returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| oe | input | 1 | Output enable, active high |
| sh_n | input | 1 | Sample strobe; falling edge starts a conversion |
| ch_sel | input | 1 | Channel select (0 = channel one, 1 = channel two) |
| pd_n | input | 1 | Power-down, active low (1 = normal operation) |
| conv_result | input | DATA_W | Result word from the quantizer stub |
| eoc_n | output | 1 | End of conversion; low while converting |
| irq_n | output | 1 | Interrupt, active low |
| bus_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| bus_data | output | DATA_W | Data bus word, zero when not driven |
| bus_chan | output | 1 | Channel tag of the latched result, zero when not driven |

## Verification
The bench measures the conversion length from the strobe edge to the rising end-of-conversion flag. A timer that is off by one shows up as 11 or 13 low cycles. It also fires a second strobe in the middle of a conversion, which a design without the busy guard would take as a restart and lengthen the conversion. A read with the chip deselected must hide the interrupt without clearing it; a design that lets read alone clear the flag would lose the pending interrupt. Power-down is applied mid-conversion: a design that still loads the latch or keeps converting would put stale data on the bus or leave the end-of-conversion flag low.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  localparam int unsigned DEF_DATA_W      = 12;
  localparam int unsigned DEF_CONV_CYCLES = 12;

  typedef enum logic {
    CH_ONE = 1'b0,
    CH_TWO = 1'b1
  } chan_e;

endpackage

// File: rtl/adc_ctl_start.sv
module adc_ctl_start (
  input  logic clk,
  input  logic rst,
  input  logic sh_n,
  input  logic cs_n,
  input  logic pd_n,
  input  logic busy_q,
  output logic start
);

  logic sh_prev_q;

  always_ff @(posedge clk) begin
    if (rst) sh_prev_q <= 1'b1;
    else     sh_prev_q <= sh_n;
  end

  // falling strobe, selected, powered, idle
  always_comb start = sh_prev_q & ~sh_n & ~cs_n & pd_n & ~busy_q;

endmodule

// File: rtl/adc_ctl_timer.sv
module adc_ctl_timer
  import adc_ctl_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = DEF_CONV_CYCLES
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  pd_n,
  input  chan_e ch_sel,
  output logic  busy_q,
  output logic  busy_nxt,
  output logic  done,
  output chan_e chan_cap_q
);

  localparam int unsigned CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last;

  always_comb begin
    last     = (cnt_q == '0);
    done     = busy_q & last & pd_n;
    busy_nxt = pd_n & (start | (busy_q & ~last));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      chan_cap_q <= CH_ONE;
    end else begin
      busy_q <= busy_nxt;
      if (start) begin
        cnt_q      <= CNT_LOAD;
        chan_cap_q <= ch_sel;
      end else if (busy_q && !last) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_ctl_result.sv
module adc_ctl_result
  import adc_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] conv_result,
  input  chan_e             chan_cap_q,
  input  logic              rd_n,
  input  logic              cs_n,
  input  logic              pd_n,
  output logic [DATA_W-1:0] data_nxt,
  output chan_e             chan_nxt,
  output logic              irq_n_q
);

  logic [DATA_W-1:0] data_q;
  chan_e             chan_q;
  logic              pend_q;
  logic              pend_nxt;
  logic              rd_clr;

  always_comb begin
    data_nxt = done ? conv_result : data_q;
    chan_nxt = done ? chan_cap_q  : chan_q;
    rd_clr   = ~rd_n & ~cs_n;
    pend_nxt = pd_n & ~rd_clr & (pend_q | done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      chan_q  <= CH_ONE;
      pend_q  <= 1'b0;
      irq_n_q <= 1'b1;
    end else begin
      data_q  <= data_nxt;
      chan_q  <= chan_nxt;
      pend_q  <= pend_nxt;
      irq_n_q <= ~(pend_nxt & rd_n);
    end
  end

endmodule

// File: rtl/adc_ctl_bus.sv
module adc_ctl_bus
  import adc_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              busy_nxt,
  input  logic [DATA_W-1:0] data_nxt,
  input  chan_e             chan_nxt,
  output logic              bus_oe_q,
  output logic [DATA_W-1:0] bus_data_q,
  output logic              bus_chan_q
);

  logic drive_nxt;

  always_comb drive_nxt = oe & ~cs_n & ~rd_n & ~busy_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe_q   <= 1'b0;
      bus_data_q <= '0;
      bus_chan_q <= 1'b0;
    end else begin
      bus_oe_q   <= drive_nxt;
      bus_data_q <= drive_nxt ? data_nxt : '0;
      bus_chan_q <= drive_nxt & chan_nxt;
    end
  end

endmodule

// File: rtl/adc_ctl_if.sv
module adc_ctl_if
  import adc_ctl_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned CONV_CYCLES = DEF_CONV_CYCLES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              oe,
  input  logic              sh_n,
  input  logic              ch_sel,
  input  logic              pd_n,
  input  logic [DATA_W-1:0] conv_result,
  output logic              eoc_n,
  output logic              irq_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_chan
);

  logic              start;
  logic              busy_q;
  logic              busy_nxt;
  logic              done;
  chan_e             chan_cap_q;
  logic [DATA_W-1:0] data_nxt;
  chan_e             chan_nxt;

  adc_ctl_start i_start (
    .clk    (clk),
    .rst    (rst),
    .sh_n   (sh_n),
    .cs_n   (cs_n),
    .pd_n   (pd_n),
    .busy_q (busy_q),
    .start  (start)
  );

  adc_ctl_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pd_n       (pd_n),
    .ch_sel     (chan_e'(ch_sel)),
    .busy_q     (busy_q),
    .busy_nxt   (busy_nxt),
    .done       (done),
    .chan_cap_q (chan_cap_q)
  );

  adc_ctl_result #(.DATA_W(DATA_W)) i_result (
    .clk         (clk),
    .rst         (rst),
    .done        (done),
    .conv_result (conv_result),
    .chan_cap_q  (chan_cap_q),
    .rd_n        (rd_n),
    .cs_n        (cs_n),
    .pd_n        (pd_n),
    .data_nxt    (data_nxt),
    .chan_nxt    (chan_nxt),
    .irq_n_q     (irq_n)
  );

  adc_ctl_bus #(.DATA_W(DATA_W)) i_bus (
    .clk        (clk),
    .rst        (rst),
    .oe         (oe),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .busy_nxt   (busy_nxt),
    .data_nxt   (data_nxt),
    .chan_nxt   (chan_nxt),
    .bus_oe_q   (bus_oe),
    .bus_data_q (bus_data),
    .bus_chan_q (bus_chan)
  );

  assign eoc_n = ~busy_q;

endmodule

// File: rtl/adc_ctl_if_chk.sv
module adc_ctl_if_chk #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic              oe,
  input logic              sh_n,
  input logic              pd_n,
  input logic              eoc_n,
  input logic              irq_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_chan
);

  localparam int unsigned RUN_W = $clog2(CONV_CYCLES + 1) + 1;
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || eoc_n) low_run <= '0;
    else              low_run <= low_run + 1'b1;
  end

  a_r2_start_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($fell(sh_n) && !cs_n && pd_n && eoc_n) |=> !eoc_n);

  a_r3_conv_bounded: assert property (@(posedge clk) disable iff (rst)
    !eoc_n |-> (low_run < RUN_W'(CONV_CYCLES)));

  a_r8_read_masks_irq: assert property (@(posedge clk) disable iff (rst)
    !rd_n |=> irq_n);

  a_r9_bus_idle_only: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> eoc_n);

  a_r9_bus_needs_read: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(oe && !cs_n && !rd_n));

  a_r9_bus_zero_when_off: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (bus_data == '0 && !bus_chan));

  a_r10_standby: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (eoc_n && irq_n));

endmodule

bind adc_ctl_if adc_ctl_if_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .oe       (oe),
  .sh_n     (sh_n),
  .pd_n     (pd_n),
  .eoc_n    (eoc_n),
  .irq_n    (irq_n),
  .bus_oe   (bus_oe),
  .bus_data (bus_data),
  .bus_chan (bus_chan)
);

// File: tb/test_adc_ctl_if.sv
module test_adc_ctl_if;

  localparam int  DW       = 12;
  localparam int  NCONV    = 12;
  localparam time CLK_PER  = 10ns;
  localparam int  WD_LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, rd_n = 1'b1, oe = 1'b0, sh_n = 1'b1, ch_sel = 1'b0, pd_n = 1'b1;
  logic [DW-1:0] conv_result = '0;
  logic          eoc_n, irq_n, bus_oe, bus_chan;
  logic [DW-1:0] bus_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  always #(CLK_PER/2) clk = ~clk;

  adc_ctl_if #(.DATA_W(DW), .CONV_CYCLES(NCONV)) i_adc_ctl_if (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .oe(oe), .sh_n(sh_n),
    .ch_sel(ch_sel), .pd_n(pd_n), .conv_result(conv_result),
    .eoc_n(eoc_n), .irq_n(irq_n), .bus_oe(bus_oe), .bus_data(bus_data),
    .bus_chan(bus_chan)
  );

  // reference model built from the requirements
  logic          m_shp, m_busy, m_pch, m_chan, m_pend, m_irqn, m_oe, m_bc;
  int            m_cnt;
  logic [DW-1:0] m_data, m_bd;

  always @(posedge clk) begin
    logic st, dn, bnx, pnx;
    if (rst) begin
      m_shp = 1; m_busy = 0; m_cnt = 0; m_pch = 0; m_data = '0; m_chan = 0;
      m_pend = 0; m_irqn = 1; m_oe = 0; m_bd = '0; m_bc = 0;
    end else begin
      st  = m_shp && !sh_n && !cs_n && pd_n && !m_busy;         // R2, R4
      dn  = m_busy && m_cnt == 0 && pd_n;                       // R3
      bnx = pd_n && (st || (m_busy && m_cnt != 0));             // R10
      if (dn) begin m_data = conv_result; m_chan = m_pch; end   // R6, R5
      if (st) begin m_cnt = NCONV - 1; m_pch = ch_sel; end
      else if (m_busy && m_cnt != 0) m_cnt = m_cnt - 1;
      pnx    = pd_n && !(!rd_n && !cs_n) && (m_pend || dn);     // R7
      m_irqn = !(pnx && rd_n);                                  // R8
      m_pend = pnx;
      m_oe   = oe && !cs_n && !rd_n && !bnx;                    // R9
      m_bd   = m_oe ? m_data : '0;
      m_bc   = m_oe && m_chan;
      m_busy = bnx;
      m_shp  = sh_n;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R3 eoc_n", 32'(eoc_n), 32'(!m_busy));
    check("R7 irq_n", 32'(irq_n), 32'(m_irqn));
    check("R9 bus_oe", 32'(bus_oe), 32'(m_oe));
    check("R6 bus_data", 32'(bus_data), 32'(m_bd));
    check("R5 bus_chan", 32'(bus_chan), 32'(m_bc));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    cs_n = 0; rd_n = 1; oe = 0; sh_n = 1; pd_n = 1;
  endtask

  // strobe a conversion and count how many cycles eoc_n reads low
  task automatic convert(input logic ch, input logic [DW-1:0] res, input bit mid_strobe,
                         output int low_cycles);
    idle_inputs(); ch_sel = ch; conv_result = res;
    cyc();
    sh_n = 0;
    cyc();
    ch_sel = ~ch;                       // R5: late change must not matter
    low_cycles = (eoc_n == 1'b0) ? 1 : 0;
    for (int i = 0; i < 40 && eoc_n == 1'b0; i++) begin
      if (mid_strobe && i == 3) sh_n = 1;
      if (mid_strobe && i == 4) sh_n = 0;   // R4: strobe inside conversion
      cyc();
      if (eoc_n == 1'b0) low_cycles++;
    end
    sh_n = 1;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc_cnt, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lows;
    void'($urandom(32'h5EED_0A1C));
    rst = 1;
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1 eoc_n", 32'(eoc_n), 1); check("R1 irq_n", 32'(irq_n), 1);
    check("R1 bus_oe", 32'(bus_oe), 0); check("R1 bus_data", 32'(bus_data), 0);
    rst = 0;
    cyc();
    check("R1 bus_chan", 32'(bus_chan), 0);

    // R2: strobe with chip deselected is ignored
    cs_n = 1; sh_n = 1; cyc(); sh_n = 0; cyc(); cyc();
    check("R2 deselected strobe", 32'(eoc_n), 1);

    // R2, R3, R7, R5, R6, R9: normal conversion on channel two
    convert(1'b1, 12'hA5C, 1'b0, lows);
    check("R3 low length", 32'(lows), NCONV);
    check("R7 irq raised", 32'(irq_n), 0);
    oe = 1; rd_n = 0; cyc();
    check("R9 bus drives", 32'(bus_oe), 1);
    check("R6 latched word", 32'(bus_data), 32'h0A5C);
    check("R5 channel two tag", 32'(bus_chan), 1);
    rd_n = 1; cyc();
    check("R7 irq cleared by read", 32'(irq_n), 1);
    check("R9 bus released", 32'(bus_oe), 0);

    // R4: extra strobe mid-conversion, channel one
    convert(1'b0, 12'h3C1, 1'b1, lows);
    check("R4 no restart", 32'(lows), NCONV);
    oe = 1; rd_n = 0; cyc();
    check("R5 channel one tag", 32'(bus_chan), 0);
    check("R6 second word", 32'(bus_data), 32'h03C1);
    rd_n = 1; oe = 0; cyc();

    // R8: read without select masks but keeps the interrupt
    convert(1'b1, 12'h777, 1'b0, lows);
    check("R7 irq raised again", 32'(irq_n), 0);
    cs_n = 1; rd_n = 0; cyc();
    check("R8 masked by read", 32'(irq_n), 1);
    rd_n = 1; cyc();
    check("R8 pending kept", 32'(irq_n), 0);
    cs_n = 0; rd_n = 0; cyc(); rd_n = 1; cyc();
    check("R7 cleared", 32'(irq_n), 1);

    // R10: power-down aborts a conversion, no latch load
    idle_inputs(); conv_result = 12'hFFF; cyc(); sh_n = 0; cyc();
    repeat (4) cyc();
    pd_n = 0; cyc();
    check("R10 eoc high", 32'(eoc_n), 1);
    check("R10 irq high", 32'(irq_n), 1);
    sh_n = 1; cyc(); sh_n = 0; cyc();
    check("R10 start blocked", 32'(eoc_n), 1);
    pd_n = 1; sh_n = 1; oe = 1; rd_n = 0; repeat (NCONV + 2) cyc();
    check("R10 no latch load", 32'(bus_data), 32'h0777);
    rd_n = 1; oe = 0; cyc();

    // random phase, model compared every cycle
    for (int k = 0; k < 4000; k++) begin
      cs_n        = ($urandom_range(0, 9) < 2);
      rd_n        = ($urandom_range(0, 9) >= 3);
      oe          = ($urandom_range(0, 9) < 7);
      sh_n        = $urandom_range(0, 1) != 0;
      ch_sel      = $urandom_range(0, 1) != 0;
      pd_n        = ($urandom_range(0, 99) >= 4);
      conv_result = DW'($urandom);
      cyc();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule